// File: doc/BRIEF.md
# Delayed Read Lead-off Wait Controller

This block sits on the target side of a PCI-style bus and decides how to answer a master that returns for a delayed upstream memory read. When the read request is queued internally, the block notes it and starts counting bus clocks. When the master later starts a transaction (a FRAME#-style start pulse), the block checks two things: whether the completion data has arrived, and how many clocks have passed since the request was queued. It then answers in one of three ways. It can assert an active-low TRDY-style strobe for one clock. It can assert an active-low STOP-style strobe for one clock to signal retry. Or it can hold the bus with wait states for a bounded window, in case the data is close to arriving.

The wait policy is governed by a 6-bit threshold in bus clocks. A return that comes earlier than the threshold is retried at once. A return at or after the threshold is held, because the read is probably near completion. Holding the lead-off phase cuts the number of retry round trips without tying up the bus for more than 16 clocks. A threshold of zero turns the wait policy off.

Only one delayed read is tracked at a time. The tracked read ends when its data is handed over with TRDY, or when the surrounding logic discards it.

States of the controller: `ST_IDLE` (waiting for a transaction start), `ST_WAIT` (inserting lead-off wait states), `ST_GRANT` (TRDY strobe clock) and `ST_RETRY` (STOP strobe clock). Transitions:
- IDLE→GRANT: data present at the start.
- IDLE→WAIT: no data, and a late return with a non-zero threshold.
- IDLE→RETRY: no data, and an early return, a zero threshold or nothing pending.
- WAIT→GRANT: data arrives.
- WAIT→RETRY: the window is used up.
- GRANT→IDLE and RETRY→IDLE: always, after one clock.

Top module: `delayed_read_leadoff`

## Requirements
- R1: After reset, `trdy_n` and `stop_n` are high and the threshold holds 18 clocks.
- R2: A read is tracked from the clock edge that samples `enq_pulse` high. Its elapsed count, as seen by a `frame_start` sampled g edges later, equals g. The count saturates as given in R8.
- R3: If a read is pending and `data_ready` is high on the edge that samples `frame_start`, then `trdy_n` is low for exactly one clock: the first clock after that edge. This holds for any elapsed count and any threshold.
- R4: If a read is pending, `data_ready` is low at the start, and the elapsed count is below a non-zero threshold, then `stop_n` is low for exactly one clock: the first clock after the start.
- R5: If a read is pending, `data_ready` is low at the start, the threshold is non-zero and the elapsed count is at or above it, then the block inserts wait states (both strobes high). Suppose `data_ready` is first sampled high at the end of the k-th clock after the start, with k from 1 to 15. Then `trdy_n` is low in clock k+1 and `stop_n` stays high.
- R6: If the data of R5 has not been sampled by the end of clock 15, `stop_n` is low in clock 16 after the start. No strobe ever comes later than clock 16.
- R7: With a threshold of 0, a start without data always gets `stop_n` in clock 1. No wait state is ever inserted.
- R8: The elapsed count saturates at 63 and does not wrap. A return 70 clocks after enqueue with a threshold of 63 is therefore held with wait states.
- R9: The tracked read is cleared when a TRDY answer is decided or when `discard` is sampled high. After that, a new `enq_pulse` starts a fresh count.
- R10: An `enq_pulse` that arrives while a read is pending is ignored. The elapsed count keeps running from the first enqueue.
- R11: A STOP (retry) answer leaves the read pending, and its count keeps running across the retry.
- R12: A `frame_start` with no read pending gets `stop_n` in clock 1, even if `data_ready` is high.
- R13: When `thresh_we` is sampled high, `thresh_din` becomes the threshold. It is used for every start sampled after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_pulse | input | 1 | Upstream read request queued internally (one clock) |
| discard | input | 1 | Drop the tracked delayed read |
| data_ready | input | 1 | Completion data for the tracked read is available |
| frame_start | input | 1 | Master starts a transaction (one clock) |
| thresh_we | input | 1 | Load a new wait threshold |
| thresh_din | input | 6 | New threshold in bus clocks (0 disables waiting) |
| trdy_n | output | 1 | Active-low data-ready strobe, one clock |
| stop_n | output | 1 | Active-low retry strobe, one clock |

## Verification
A corrupted elapsed count or pending flag never shows up directly at the pins. It shows up as the wrong kind of answer: a retry in clock 1 where wait states were due, or a 16-clock hold where an immediate retry was due. So every check records which strobe fired and in which clock after the start. A stuck wait counter shows up within 16 clocks as a missing or late STOP. A lost clear shows up as a hold on the next short-gap read. The sweeps cross threshold, return gap (including the saturation region) and data arrival clock, so each decision boundary is hit from both sides.

// File: rtl/leadoff_pkg.sv
package leadoff_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_GRANT,
        ST_RETRY
    } leadoff_state_e;

endpackage

// File: rtl/leadoff_age_tracker.sv
module leadoff_age_tracker #(
    parameter int AGE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq,
    input  logic             clear,
    output logic             pending,
    output logic [AGE_W-1:0] age
);

    localparam logic [AGE_W-1:0] AGE_MAX = '1;
    localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
            age     <= '0;
        end else if (clear) begin
            pending <= 1'b0;
            age     <= '0;
        end else if (enq && !pending) begin
            pending <= 1'b1;
            age     <= AGE_ONE;
        end else if (pending && (age != AGE_MAX)) begin
            age     <= age + AGE_ONE;
        end
    end

    AST_AGE_STARTS_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> age == AGE_ONE); // R2

    AST_AGE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && age == AGE_MAX && !clear) |=> age == AGE_MAX); // R8

    AST_ENQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && enq && !clear) |=> (pending && age >= $past(age))); // R10

endmodule

// File: rtl/leadoff_thresh_reg.sv
module leadoff_thresh_reg #(
    parameter int AGE_W      = 6,
    parameter int THRESH_RST = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AGE_W-1:0] din,
    output logic [AGE_W-1:0] thresh
);

    localparam logic [AGE_W-1:0] RST_VAL = AGE_W'(THRESH_RST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thresh <= RST_VAL;
        end else if (we) begin
            thresh <= din;
        end
    end

    AST_THRESH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> thresh == $past(din)); // R13

endmodule

// File: rtl/leadoff_fsm.sv
module leadoff_fsm
    import leadoff_pkg::*;
#(
    parameter int AGE_W   = 6,
    parameter int MAX_LAT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             data_ready,
    input  logic             pending,
    input  logic [AGE_W-1:0] age,
    input  logic [AGE_W-1:0] thresh,
    output logic             complete,
    output logic             busy,
    output logic             trdy_n,
    output logic             stop_n
);

    localparam int               LAT_W = $clog2(MAX_LAT);
    localparam logic [LAT_W-1:0] WLAST = LAT_W'(MAX_LAT - 1);
    localparam logic [LAT_W-1:0] WONE  = LAT_W'(1);

    leadoff_state_e   state, nxt;
    logic [LAT_W-1:0] wcnt, wcnt_nxt;
    logic             late_miss;

    assign late_miss = pending && !data_ready && (thresh != '0) && (age >= thresh);

    always_comb begin
        nxt      = state;
        wcnt_nxt = wcnt;
        unique case (state)
            ST_IDLE: begin
                if (frame_start) begin
                    if (pending && data_ready) begin
                        nxt = ST_GRANT;
                    end else if (late_miss) begin
                        nxt      = ST_WAIT;
                        wcnt_nxt = WONE;
                    end else begin
                        nxt = ST_RETRY;
                    end
                end
            end
            ST_WAIT: begin
                if (data_ready) begin
                    nxt = ST_GRANT;
                end else if (wcnt == WLAST) begin
                    nxt = ST_RETRY;
                end else begin
                    wcnt_nxt = wcnt + WONE;
                end
            end
            ST_GRANT: nxt = ST_IDLE;
            ST_RETRY: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            wcnt  <= '0;
        end else begin
            state <= nxt;
            wcnt  <= wcnt_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trdy_n <= 1'b1;
            stop_n <= 1'b1;
        end else begin
            trdy_n <= (nxt != ST_GRANT);
            stop_n <= (nxt != ST_RETRY);
        end
    end

    assign complete = (nxt == ST_GRANT) && (state != ST_GRANT);
    assign busy     = (state != ST_IDLE);

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!trdy_n && !stop_n)); // R3

    AST_DATA_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && frame_start && pending && data_ready) |=> !trdy_n); // R3

    AST_EARLY_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && frame_start && pending && !data_ready && age < thresh)
        |=> !stop_n); // R4

    AST_WAIT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && data_ready) |=> (!trdy_n && stop_n)); // R5

    AST_ZERO_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && frame_start && thresh == '0) |=> state != ST_WAIT); // R7

    AST_NONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && frame_start && !pending) |=> !stop_n); // R12

    AST_ONE_CLOCK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n || !stop_n) |=> (trdy_n && stop_n)); // R3

endmodule

// File: rtl/delayed_read_leadoff.sv
module delayed_read_leadoff #(
    parameter int AGE_W      = 6,
    parameter int THRESH_RST = 18,
    parameter int MAX_LAT    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_pulse,
    input  logic             discard,
    input  logic             data_ready,
    input  logic             frame_start,
    input  logic             thresh_we,
    input  logic [AGE_W-1:0] thresh_din,
    output logic             trdy_n,
    output logic             stop_n
);

    localparam int BND_W = $clog2(MAX_LAT + 1);

    logic             pending;
    logic [AGE_W-1:0] age;
    logic [AGE_W-1:0] thresh;
    logic             complete;
    logic             busy;
    logic             clear;

    assign clear = complete || discard;

    leadoff_age_tracker #(.AGE_W(AGE_W)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .enq     (enq_pulse),
        .clear   (clear),
        .pending (pending),
        .age     (age)
    );

    leadoff_thresh_reg #(.AGE_W(AGE_W), .THRESH_RST(THRESH_RST)) u_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (thresh_we),
        .din    (thresh_din),
        .thresh (thresh)
    );

    leadoff_fsm #(.AGE_W(AGE_W), .MAX_LAT(MAX_LAT)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .data_ready  (data_ready),
        .pending     (pending),
        .age         (age),
        .thresh      (thresh),
        .complete    (complete),
        .busy        (busy),
        .trdy_n      (trdy_n),
        .stop_n      (stop_n)
    );

    // Lead-off bound watcher: counts clocks from an accepted start to its strobe.
    logic             bnd_open;
    logic [BND_W-1:0] bnd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bnd_open <= 1'b0;
            bnd_cnt  <= '0;
        end else if (frame_start && !busy) begin
            bnd_open <= 1'b1;
            bnd_cnt  <= BND_W'(1);
        end else if (bnd_open && (!trdy_n || !stop_n)) begin
            bnd_open <= 1'b0;
        end else if (bnd_open && bnd_cnt != '1) begin
            bnd_cnt  <= bnd_cnt + BND_W'(1);
        end
    end

    AST_LEADOFF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_open |-> bnd_cnt <= BND_W'(MAX_LAT)); // R6

    AST_RESET_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (trdy_n && stop_n)); // R1

endmodule

// File: tb/delayed_read_leadoff_test.sv
`timescale 1ns/1ps
module delayed_read_leadoff_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enq_pulse = 1'b0;
    logic       discard = 1'b0;
    logic       data_ready = 1'b0;
    logic       frame_start = 1'b0;
    logic       thresh_we = 1'b0;
    logic [5:0] thresh_din = '0;
    logic       trdy_n;
    logic       stop_n;

    int total = 0;
    int failed = 0;
    int cur_thr = 18;
    bit done = 1'b0;

    localparam int K_NONE = 99;
    localparam int GRANT  = 1;
    localparam int RETRY  = 2;

    always #4 clk = ~clk;

    delayed_read_leadoff uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enq_pulse   (enq_pulse),
        .discard     (discard),
        .data_ready  (data_ready),
        .frame_start (frame_start),
        .thresh_we   (thresh_we),
        .thresh_din  (thresh_din),
        .trdy_n      (trdy_n),
        .stop_n      (stop_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_enq();
        enq_pulse = 1'b1;
        @(negedge clk);
        enq_pulse = 1'b0;
    endtask

    task automatic pulse_discard();
        discard = 1'b1;
        @(negedge clk);
        discard = 1'b0;
    endtask

    task automatic set_thr(input int v);
        thresh_we  = 1'b1;
        thresh_din = 6'(v);
        @(negedge clk);
        thresh_we  = 1'b0;
        cur_thr    = v;
    endtask

    // Result code: kind*100 + clock index after the start; 999 for a bad strobe count.
    task automatic start_and_watch(input int k, input int exp_kind, input int exp_n,
                                   input string tag);
        int code = 0;
        int strobes = 0;
        int expc = exp_kind * 100 + exp_n;
        frame_start = 1'b1;
        data_ready  = (k == 0);
        for (int n = 1; n <= 18; n++) begin
            @(negedge clk);
            frame_start = 1'b0;
            if (!trdy_n || !stop_n) begin
                strobes++;
                if (code == 0) code = (!trdy_n ? GRANT : RETRY) * 100 + n;
            end
            if (n == k) data_ready = 1'b1;
        end
        data_ready = 1'b0;
        if (strobes != 1) code = 999;
        check(code == expc, tag, code, expc);
    endtask

    task automatic run_read(input int gap, input int k);
        int sat = (gap > 63) ? 63 : gap;
        int kind;
        int nclk;
        string tag;
        if (k == 0) begin
            kind = GRANT; nclk = 1; tag = "R3";
        end else if (cur_thr == 0) begin
            kind = RETRY; nclk = 1; tag = "R7";
        end else if (sat < cur_thr) begin
            kind = RETRY; nclk = 1; tag = "R4";
        end else if (k <= 15) begin
            kind = GRANT; nclk = k + 1; tag = (gap > 63) ? "R8" : "R5";
        end else begin
            kind = RETRY; nclk = 16; tag = (gap > 63) ? "R8" : "R6";
        end
        pulse_discard();
        pulse_enq();
        idle(gap - 1);
        start_and_watch(k, kind, nclk, tag);
    endtask

    initial begin
        int thrs[5] = '{0, 1, 7, 18, 63};
        int gaps[11] = '{1, 2, 6, 7, 8, 17, 18, 19, 62, 63, 70};
        int ks[5] = '{0, 1, 4, 15, K_NONE};
        repeat (3) @(negedge clk);
        check(trdy_n == 1'b1, "R1", trdy_n, 1);
        check(stop_n == 1'b1, "R1", stop_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(trdy_n && stop_n, "R1", {trdy_n, stop_n}, 3);

        // R1: default threshold of 18 clocks
        pulse_enq(); idle(16);
        start_and_watch(K_NONE, RETRY, 1, "R1");
        pulse_discard(); pulse_enq(); idle(17);
        start_and_watch(3, GRANT, 4, "R1");

        // R2: elapsed count equals the gap, right at the boundary
        set_thr(9);
        run_read(8, K_NONE);
        run_read(9, 2);

        // R13: new threshold takes effect
        set_thr(5);
        run_read(4, K_NONE);
        run_read(5, 3);

        // R12: nothing pending
        pulse_discard(); idle(2);
        start_and_watch(0, RETRY, 1, "R12");

        // R10: second enqueue ignored
        set_thr(8);
        pulse_discard(); pulse_enq(); idle(4); pulse_enq(); idle(4);
        start_and_watch(2, GRANT, 3, "R10");

        // R9: completion cleared the read, fresh count from new enqueue
        pulse_enq(); idle(2);
        start_and_watch(K_NONE, RETRY, 1, "R9");

        // R11: read still pending after retry, count kept running
        start_and_watch(1, GRANT, 2, "R11");

        // R9: discard clears the tracked read
        pulse_enq(); idle(20); pulse_discard(); pulse_enq(); idle(2);
        start_and_watch(K_NONE, RETRY, 1, "R9");

        // Sweep: threshold x gap x data arrival
        foreach (thrs[t]) begin
            set_thr(thrs[t]);
            foreach (gaps[g]) begin
                foreach (ks[j]) run_read(gaps[g], ks[j]);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            failed++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule